// File: doc/BRIEF.md
# ADC Power-State and Conversion Sequencer

This block is the digital control sequencer for a single-channel delta-sigma converter. It decides when the analog front end is powered, when a conversion is launched, and when a finished result is flagged as ready. The modulator, the decimation filter and the serial read-out sit outside it. The only thing the block sees from them is a one-cycle pulse that marks the end of each conversion.

After power-up, and again every time the host releases the chip select, the analog enable is raised. A settling window of a fixed number of internal clocks then runs before the first conversion strobe. The mode input picks between two behaviours:

- **Single mode:** one conversion, after which the block parks in a sleep state. In sleep the analog circuitry stays powered and the result stays flagged.
- **Continuous mode:** each end-of-conversion pulse immediately relaunches a conversion.

Raising the chip select drops to shutdown, which cuts the analog enable. Losing the supply-good input forces the reset state at once.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While rst_ni is low, state_o is 0 (reset) and analog_en_o, conv_start_o and data_ready_o are all 0.
- R2: state_o is a 3-bit code: 0 reset, 1 startup, 2 converting, 3 sleep, 4 shutdown.
- R3: From reset, with supply_ok_i high and cs_ni low, the block enters startup on the next clock. It then stays in startup for exactly SETTLE_CYCLES (default 32) clock cycles. After that it enters converting, and conv_start_o is high for the first converting cycle only.
- R4: analog_en_o is 1 exactly when state_o is startup, converting or sleep.
- R5: With cs_ni high and supply_ok_i high, any state moves to shutdown on the next clock, and data_ready_o reads 0 there. From reset, with cs_ni high, the block goes to shutdown rather than startup.
- R6: In single mode (cont_mode_i = 0), a conv_done_i pulse during converting moves the block to sleep on the next clock, with data_ready_o = 1.
- R7: In sleep, conv_done_i and cont_mode_i are ignored. The block stays in sleep, issues no conv_start_o and keeps data_ready_o = 1 until cs_ni rises.
- R8: Pulling cs_ni low in shutdown enters startup on the next clock. The full SETTLE_CYCLES window runs again, and converting is then entered with data_ready_o = 0.
- R9: In continuous mode (cont_mode_i = 1), a conv_done_i pulse during converting keeps the block converting. On the next cycle conv_start_o = 1 and data_ready_o = 1. The block never enters sleep in this mode.
- R10: If cs_ni is high during converting, the conversion is aborted and the block enters shutdown. This holds even when conv_done_i arrives in the same cycle, and data_ready_o stays 0.
- R11: A low supply_ok_i in any state forces reset on the next clock and clears data_ready_o. While it stays low, no conv_start_o is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select; high requests shutdown |
| supply_ok_i | input | 1 | Supply above threshold |
| cont_mode_i | input | 1 | 1 = continuous conversion, 0 = single conversion |
| conv_done_i | input | 1 | One-cycle end-of-conversion pulse from the decimator |
| state_o | output | 3 | Current state code (see R2) |
| analog_en_o | output | 1 | Enable for the analog circuitry |
| conv_start_o | output | 1 | One-cycle conversion launch strobe |
| data_ready_o | output | 1 | A completed result is waiting |

## Verification
The bench builds the block with the default SETTLE_CYCLES of 32, which is the settling length the sequencer must honour. At that value the window is short enough to count one cycle at a time on every entry to startup. This includes a re-entry after the window was cut short by the chip select, which shows that the counter reloads rather than resumes. The 3-bit state code and the settle counter both run at their full widths, so every state transition and the counter's terminal value are reached directly.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_STARTUP  = 3'd1,
    ST_CONVERT  = 3'd2,
    ST_SLEEP    = 3'd3,
    ST_SHUTDOWN = 3'd4
  } seq_state_e;
endpackage

// File: rtl/adc_seq_settle.sv
module adc_seq_settle #(
  parameter int SETTLE_CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  seq_state_e state_q_i,
  input  logic       cs_ni,
  input  logic       supply_ok_i,
  input  logic       cont_mode_i,
  input  logic       conv_done_i,
  input  logic       settle_done_i,
  output seq_state_e state_d_o,
  output logic       launch_o,
  output logic       rearm_o,
  output logic       accept_o
);
  always_comb begin
    state_d_o = state_q_i;
    launch_o  = 1'b0;
    rearm_o   = 1'b0;
    accept_o  = 1'b0;
    if (!supply_ok_i) begin
      state_d_o = ST_RESET;
    end else begin
      unique case (state_q_i)
        ST_RESET:    state_d_o = cs_ni ? ST_SHUTDOWN : ST_STARTUP;
        ST_STARTUP: begin
          if (cs_ni) state_d_o = ST_SHUTDOWN;
          else if (settle_done_i) begin
            state_d_o = ST_CONVERT;
            launch_o  = 1'b1;
          end
        end
        ST_CONVERT: begin
          // chip select wins over a coincident done pulse
          if (cs_ni) state_d_o = ST_SHUTDOWN;
          else if (conv_done_i) begin
            accept_o = 1'b1;
            if (cont_mode_i) rearm_o   = 1'b1;
            else             state_d_o = ST_SLEEP;
          end
        end
        ST_SLEEP:    if (cs_ni)  state_d_o = ST_SHUTDOWN;
        ST_SHUTDOWN: if (!cs_ni) state_d_o = ST_STARTUP;
        default:     state_d_o = ST_RESET;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ready.sv
module adc_seq_ready (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic set_i,
  output logic ready_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ready_o <= 1'b0;
    else if (clear_i) ready_o <= 1'b0;
    else if (set_i)   ready_o <= 1'b1;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       supply_ok_i,
  input  logic       cont_mode_i,
  input  logic       conv_done_i,
  output logic [2:0] state_o,
  output logic       analog_en_o,
  output logic       conv_start_o,
  output logic       data_ready_o
);
  seq_state_e state_q, state_d;
  logic launch, rearm, accept, settle_done, start_q;

  adc_seq_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i ((state_d == ST_STARTUP) && (state_q != ST_STARTUP)),
    .run_i  (state_q == ST_STARTUP),
    .done_o (settle_done)
  );

  adc_seq_fsm u_fsm (
    .state_q_i     (state_q),
    .cs_ni         (cs_ni),
    .supply_ok_i   (supply_ok_i),
    .cont_mode_i   (cont_mode_i),
    .conv_done_i   (conv_done_i),
    .settle_done_i (settle_done),
    .state_d_o     (state_d),
    .launch_o      (launch),
    .rearm_o       (rearm),
    .accept_o      (accept)
  );

  adc_seq_ready u_ready (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i ((state_d == ST_RESET) || (state_d == ST_SHUTDOWN) || launch),
    .set_i   (accept),
    .ready_o (data_ready_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= launch | rearm;
    end
  end

  assign state_o      = state_q;
  assign conv_start_o = start_q;
  assign analog_en_o  = (state_q == ST_STARTUP) || (state_q == ST_CONVERT) ||
                        (state_q == ST_SLEEP);
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       supply_ok_i,
  input logic       cont_mode_i,
  input logic       conv_done_i,
  input logic [2:0] state_o,
  input logic       analog_en_o,
  input logic       conv_start_o,
  input logic       data_ready_o
);
  localparam int CW = $clog2(SETTLE_CYCLES) + 2;
  logic [CW-1:0] stay_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  stay_q <= '0;
    else if (state_o == ST_STARTUP) stay_q <= stay_q + CW'(1);
    else                          stay_q <= '0;
  end

  logic cv_ok;
  assign cv_ok = (state_o == ST_CONVERT) && !cs_ni && supply_ok_i;

  assert_settle_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_CONVERT && stay_q != '0) |-> stay_q == CW'(SETTLE_CYCLES));

  assert_start_in_convert_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (state_o == ST_CONVERT) && analog_en_o);

  assert_cs_shutdown_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && supply_ok_i) |=> (state_o == ST_SHUTDOWN) && !data_ready_o && !analog_en_o);

  assert_single_sleep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cv_ok && conv_done_i && !cont_mode_i) |=> (state_o == ST_SLEEP) && data_ready_o);

  assert_cont_rearm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cv_ok && conv_done_i && cont_mode_i) |=> (state_o == ST_CONVERT) && conv_start_o && data_ready_o);

  assert_supply_loss_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (state_o == ST_RESET) && !data_ready_o && !conv_start_o);

  assert_sleep_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SLEEP && !cs_ni && supply_ok_i) |=> (state_o == ST_SLEEP) && !conv_start_o && $stable(data_ready_o));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .supply_ok_i(supply_ok_i),
  .cont_mode_i(cont_mode_i), .conv_done_i(conv_done_i), .state_o(state_o),
  .analog_en_o(analog_en_o), .conv_start_o(conv_start_o), .data_ready_o(data_ready_o)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
  localparam int SETTLE = 32;
  localparam int S_RST = 0, S_STUP = 1, S_CONV = 2, S_SLP = 3, S_SHDN = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b0, supply_ok = 1'b1, cont_mode = 1'b0, conv_done = 1'b0;
  logic [2:0] state;
  logic analog_en, conv_start, data_ready;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl #(.SETTLE_CYCLES(SETTLE)) u_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .supply_ok_i(supply_ok),
    .cont_mode_i(cont_mode), .conv_done_i(conv_done), .state_o(state),
    .analog_en_o(analog_en), .conv_start_o(conv_start), .data_ready_o(data_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // called right after the edge that entered startup
  task automatic settle_and_launch(input string req);
    int n = 0;
    while (state == 3'(S_STUP) && n < 200) begin
      chk({req, "/R4 en in startup"}, analog_en, 1);
      n++;
      tick();
    end
    chk({req, " settle length"}, n, SETTLE);
    chk({req, " state convert"}, state, S_CONV);
    chk({req, "/R3 start strobe"}, conv_start, 1);
    chk({req, " ready low at launch"}, data_ready, 0);
    tick();
    chk({req, "/R3 strobe one cycle"}, conv_start, 0);
  endtask

  task automatic t_reset();
    #5;
    chk("R1 state", state, S_RST);
    chk("R1 en", analog_en, 0);
    chk("R1 start", conv_start, 0);
    chk("R1 ready", data_ready, 0);
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    chk("R3 enter startup", state, S_STUP);
    settle_and_launch("R3");
    chk("R2 convert code", state, 2);
  endtask

  task automatic t_single();
    cont_mode = 1'b0;
    tick(); tick();
    conv_done = 1'b1; tick(); conv_done = 1'b0;
    chk("R6 sleep", state, S_SLP);
    chk("R6 ready", data_ready, 1);
    chk("R4 en in sleep", analog_en, 1);
    conv_done = 1'b1; cont_mode = 1'b1; tick();
    conv_done = 1'b0; tick();
    cont_mode = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk("R7 stay sleep", state, S_SLP);
      chk("R7 no start", conv_start, 0);
      chk("R7 ready held", data_ready, 1);
      tick();
    end
  endtask

  task automatic t_shutdown_restart();
    cs_ni = 1'b1; tick();
    chk("R5 shutdown", state, S_SHDN);
    chk("R5/R4 en off", analog_en, 0);
    chk("R5 ready cleared", data_ready, 0);
    tick(); tick();
    chk("R5 hold shutdown", state, S_SHDN);
    cs_ni = 1'b0; tick();
    chk("R8 restart startup", state, S_STUP);
    settle_and_launch("R8");
  endtask

  task automatic t_continuous();
    cont_mode = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick(); tick(); tick();
      chk("R9 no stray start", conv_start, 0);
      conv_done = 1'b1; tick(); conv_done = 1'b0;
      chk("R9 stay convert", state, S_CONV);
      chk("R9 rearm strobe", conv_start, 1);
      chk("R9 ready", data_ready, 1);
      tick();
      chk("R9 strobe one cycle", conv_start, 0);
    end
    cont_mode = 1'b0;
  endtask

  task automatic t_abort();
    cs_ni = 1'b1; tick(); cs_ni = 1'b0; tick();
    settle_and_launch("R10 relaunch");
    tick(); tick();
    cs_ni = 1'b1; conv_done = 1'b1; tick(); conv_done = 1'b0;
    chk("R10 abort shutdown", state, S_SHDN);
    chk("R10 no ready", data_ready, 0);
    chk("R10 no start", conv_start, 0);
    cs_ni = 1'b0; tick();
    chk("R8 startup", state, S_STUP);
    for (int i = 0; i < 10; i++) tick();
    cs_ni = 1'b1; tick();
    chk("R5 cut startup", state, S_SHDN);
    cs_ni = 1'b0; tick();
    settle_and_launch("R8 reload");
  endtask

  task automatic t_supply();
    conv_done = 1'b1; tick(); conv_done = 1'b0;
    chk("R6 sleep before loss", data_ready, 1);
    supply_ok = 1'b0; tick();
    chk("R11 reset", state, S_RST);
    chk("R11 ready cleared", data_ready, 0);
    chk("R11/R4 en off", analog_en, 0);
    for (int i = 0; i < 40; i++) begin
      chk("R11 no start", conv_start, 0);
      chk("R11 held", state, S_RST);
      tick();
    end
    supply_ok = 1'b1; tick();
    chk("R3 startup after supply", state, S_STUP);
    for (int i = 0; i < 5; i++) tick();
    supply_ok = 1'b0; tick();
    chk("R11 loss in startup", state, S_RST);
    cs_ni = 1'b1; supply_ok = 1'b1; tick();
    chk("R5 reset to shutdown", state, S_SHDN);
    cs_ni = 1'b0; tick();
    settle_and_launch("R11 recover");
  endtask

  initial begin
    t_reset();
    t_single();
    t_shutdown_restart();
    t_continuous();
    t_abort();
    t_supply();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule